// File: doc/BRIEF.md
# RTC Alarm Match Unit

This block watches the calendar and time fields of a real-time clock and raises an alarm when they agree with a programmed alarm setting. An external timekeeping counter supplies second, minute, hour, day-of-month and month as two-digit BCD values, and pulses a one-cycle tick each time those fields take a new value. Five alarm registers hold the alarm values. Each register also carries one repeat bit, and the five repeat bits together form a code. The code picks which fields must agree, so the alarm can repeat every second, minute, hour, day, month or year.

When the selected fields agree on a tick, the alarm flag is set. The flag can also drive an active-low interrupt line, which is modelled as an output-enable plus data pair. The interrupt is driven only when the flag-enable control bit is set. While the system runs from its backup battery, the battery-alarm enable bit must be set as well. A read strobe on the flags register returns the flag value held before the read, then clears both the flag and the interrupt. A power-up pulse clears both enable bits, so an alarm raised during power-up only records the flag.

Top module: `rtc_alarm_top`

## Requirements
- R1: Register writes use `wrSel`. Selects 0 to 4 address the second, minute, hour, day and month alarm registers. In each, `wrData[6:0]` is the BCD alarm value and `wrData[7]` is one repeat bit: select k holds repeat bit k, bit 0 being the second register. Select 5 is control, where `wrData[0]` is the flag enable and `wrData[1]` is the battery-alarm enable.
- R2: The repeat code is {month bit, day bit, hour bit, minute bit, second bit}. The fields it selects for matching are:
  - 11111: none.
  - 11110: seconds.
  - 11100: minutes and seconds.
  - 11000: hours, minutes and seconds.
  - 10000: day, hours, minutes and seconds.
  - 00000: all five fields.
- R3: Any other repeat code behaves exactly like 11111, so every tick matches.
- R4: The alarm flag is set in the cycle after a tick on which the selected fields match. Without a tick, the flag is never set.
- R5: On main power, `irqOe` goes high in the same cycle as the flag only when the flag enable is set. With the enable clear, `irqOe` stays low.
- R6: A read strobe places the flag value from before the read on `rdAf` in the next cycle, then clears the flag and releases `irqOe`. If a match lands in the same cycle as the read, the flag stays set.
- R7: While `onBattery` is high, `irqOe` asserts on a match only when both the flag enable and the battery-alarm enable are set.
- R8: A `pwrUp` pulse clears both enable bits, so a later match sets the flag without driving `irqOe`.
- R9: With repeat code 00000 and a day alarm value of zero, the alarm is disabled and the flag is never set.
- R10: After reset, every register is zero, `irqOe` is low, `irqData` is high and `rdAf` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle strobe: time fields hold a new value |
| curSec | input | 7 | Current seconds, BCD |
| curMin | input | 7 | Current minutes, BCD |
| curHour | input | 7 | Current hours, BCD |
| curDay | input | 7 | Current day of month, BCD |
| curMonth | input | 7 | Current month, BCD |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select for the write |
| wrData | input | 8 | Write data |
| rdFlags | input | 1 | Flags register read strobe |
| pwrUp | input | 1 | Power-up pulse |
| onBattery | input | 1 | System is on backup battery |
| irqOe | output | 1 | Interrupt output enable (line driven low) |
| irqData | output | 1 | Interrupt line level: 0 while driven, 1 when released |
| rdAf | output | 1 | Alarm flag value returned by the last read |

## Verification
The hardest case to reach is a tick and a flags read in the same cycle. The read must return the old flag while the new match keeps the flag set. The bench arranges this by driving a matching tick and the read strobe on the same falling edge, then issuing a second read to show that the flag survived. Every one of the 32 repeat codes is swept against six field patterns (all fields equal, or exactly one field different), which reaches the illegal-code fallback and each match boundary.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int NUM_FIELDS = 5;
  localparam int DAY_IDX    = 3;

  typedef enum logic [2:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DAY   = 3'd3,
    SEL_MONTH = 3'd4,
    SEL_CTRL  = 3'd5
  } regSel_e;

  typedef enum logic [2:0] {
    EVERY_SEC,
    EVERY_MIN,
    EVERY_HOUR,
    EVERY_DAY,
    EVERY_MONTH,
    EVERY_YEAR
  } repeatMode_e;

  typedef struct packed {
    logic setAf;
    logic clrAf;
    logic capRead;
    logic setIrq;
    logic clrIrq;
    logic clrEnables;
  } ctrlStrobe_t;

endpackage

// File: rtl/rtc_alarm_datapath.sv
module rtc_alarm_datapath
  import rtc_alarm_pkg::*;
#(
  parameter int VAL_W = 7,
  localparam int DATA_W = VAL_W + 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                wrEn,
  input  logic [2:0]                          wrSel,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [NUM_FIELDS-1:0][VAL_W-1:0]    curFields,
  input  ctrlStrobe_t                         strb,
  output logic [NUM_FIELDS-1:0]               fieldEq,
  output logic [NUM_FIELDS-1:0]               rptCode,
  output logic                                dayIsZero,
  output logic                                afeBit,
  output logic                                abeBit,
  output logic                                afFlag,
  output logic                                irqPend,
  output logic                                rdAf
);

  logic [NUM_FIELDS-1:0][VAL_W-1:0] alarmVal;

  // One alarm register per time field: value plus one repeat bit.
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN) begin
        alarmVal[i] <= '0;
        rptCode[i]  <= 1'b0;
      end else if (wrEn && wrSel == 3'(i)) begin
        alarmVal[i] <= wrData[VAL_W-1:0];
        rptCode[i]  <= wrData[DATA_W-1];
      end
    end

    assign fieldEq[i] = (curFields[i] == alarmVal[i]);
  end

  assign dayIsZero = (alarmVal[DAY_IDX] == '0);

  // Control bits; the power-up clear beats a write in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      afeBit <= 1'b0;
      abeBit <= 1'b0;
    end else if (strb.clrEnables) begin
      afeBit <= 1'b0;
      abeBit <= 1'b0;
    end else if (wrEn && wrSel == SEL_CTRL) begin
      afeBit <= wrData[0];
      abeBit <= wrData[1];
    end
  end

  // Flag, interrupt latch and read-back register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      afFlag  <= 1'b0;
      irqPend <= 1'b0;
      rdAf    <= 1'b0;
    end else begin
      if (strb.setAf)       afFlag <= 1'b1;
      else if (strb.clrAf)  afFlag <= 1'b0;

      if (strb.setIrq)      irqPend <= 1'b1;
      else if (strb.clrIrq) irqPend <= 1'b0;

      if (strb.capRead)     rdAf <= afFlag;
    end
  end

  p_pwrup_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEnables |=> (!afeBit && !abeBit));

  p_read_prior_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.capRead |=> (rdAf == $past(afFlag)));

  p_flag_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (afFlag && !strb.clrAf) |=> afFlag);

endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  secTick,
  input  logic                  rdFlags,
  input  logic                  pwrUp,
  input  logic                  onBattery,
  input  logic [NUM_FIELDS-1:0] fieldEq,
  input  logic [NUM_FIELDS-1:0] rptCode,
  input  logic                  dayIsZero,
  input  logic                  afeBit,
  input  logic                  abeBit,
  input  logic                  afFlag,
  output ctrlStrobe_t           strb
);

  repeatMode_e           mode;
  logic                  codeLegal;
  logic [NUM_FIELDS-1:0] needMask;
  logic                  alarmOff;
  logic                  hit;
  logic                  irqGate;

  // Repeat code decode; unknown codes fall back to every second.
  always_comb begin
    codeLegal = 1'b1;
    case (rptCode)
      5'b11111: mode = EVERY_SEC;
      5'b11110: mode = EVERY_MIN;
      5'b11100: mode = EVERY_HOUR;
      5'b11000: mode = EVERY_DAY;
      5'b10000: mode = EVERY_MONTH;
      5'b00000: mode = EVERY_YEAR;
      default: begin
        mode      = EVERY_SEC;
        codeLegal = 1'b0;
      end
    endcase
  end

  // Fields that must agree, bit 0 = seconds.
  always_comb begin
    case (mode)
      EVERY_MIN:   needMask = 5'b00001;
      EVERY_HOUR:  needMask = 5'b00011;
      EVERY_DAY:   needMask = 5'b00111;
      EVERY_MONTH: needMask = 5'b01111;
      EVERY_YEAR:  needMask = 5'b11111;
      default:     needMask = 5'b00000;
    endcase
  end

  assign alarmOff = (rptCode == '0) && dayIsZero;
  assign hit      = secTick && !alarmOff && (&(fieldEq | ~needMask));
  assign irqGate  = afeBit && !pwrUp && (!onBattery || abeBit);

  always_comb begin
    strb            = '0;
    strb.setAf      = hit;
    strb.clrAf      = rdFlags && !hit;
    strb.capRead    = rdFlags;
    strb.setIrq     = hit && irqGate;
    strb.clrIrq     = (rdFlags || pwrUp) && !(hit && irqGate);
    strb.clrEnables = pwrUp;
  end

  p_flag_needs_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(afFlag) |-> $past(secTick));

  p_illegal_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !codeLegal) |-> strb.setAf);

  p_disabled_alarm_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((rptCode == '0) && dayIsZero) |-> !strb.setAf);

  p_year_needs_month_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rptCode == '0 && !fieldEq[4]) |-> !strb.setAf);

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_alarm_pkg::*;
#(
  parameter int VAL_W = 7,
  localparam int DATA_W = VAL_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [VAL_W-1:0]  curSec,
  input  logic [VAL_W-1:0]  curMin,
  input  logic [VAL_W-1:0]  curHour,
  input  logic [VAL_W-1:0]  curDay,
  input  logic [VAL_W-1:0]  curMonth,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdFlags,
  input  logic              pwrUp,
  input  logic              onBattery,
  output logic              irqOe,
  output logic              irqData,
  output logic              rdAf
);

  logic [NUM_FIELDS-1:0][VAL_W-1:0] curFields;
  logic [NUM_FIELDS-1:0]            fieldEq;
  logic [NUM_FIELDS-1:0]            rptCode;
  logic                             dayIsZero;
  logic                             afeBit;
  logic                             abeBit;
  logic                             afFlag;
  logic                             irqPend;
  ctrlStrobe_t                      strb;

  assign curFields = {curMonth, curDay, curHour, curMin, curSec};

  rtc_alarm_datapath #(.VAL_W(VAL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .curFields (curFields),
    .strb      (strb),
    .fieldEq   (fieldEq),
    .rptCode   (rptCode),
    .dayIsZero (dayIsZero),
    .afeBit    (afeBit),
    .abeBit    (abeBit),
    .afFlag    (afFlag),
    .irqPend   (irqPend),
    .rdAf      (rdAf)
  );

  rtc_alarm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .secTick   (secTick),
    .rdFlags   (rdFlags),
    .pwrUp     (pwrUp),
    .onBattery (onBattery),
    .fieldEq   (fieldEq),
    .rptCode   (rptCode),
    .dayIsZero (dayIsZero),
    .afeBit    (afeBit),
    .abeBit    (abeBit),
    .afFlag    (afFlag),
    .strb      (strb)
  );

  assign irqOe   = irqPend;
  assign irqData = ~irqPend;

  p_irq_needs_afe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOe) |-> $past(afeBit));

  p_backup_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqOe) && $past(onBattery)) |-> $past(abeBit));

  p_irq_with_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqOe |-> afFlag);

  p_read_releases_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdFlags && !secTick) |=> !irqOe);

endmodule

// File: tb/tb_rtc_alarm_top.sv
module tb_rtc_alarm_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [6:0] curSec = '0, curMin = '0, curHour = '0, curDay = '0, curMonth = '0;
  logic       wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic       rdFlags = 1'b0;
  logic       pwrUp = 1'b0;
  logic       onBattery = 1'b0;
  logic       irqOe, irqData, rdAf;

  int checks = 0;
  int errors = 0;

  // Alarm values used throughout, index 0 = seconds.
  logic [6:0] alarmSet [5] = '{7'h45, 7'h30, 7'h12, 7'h15, 7'h09};

  always #2 clk = ~clk;

  rtc_alarm_top dut (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .curDay(curDay), .curMonth(curMonth),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdFlags(rdFlags), .pwrUp(pwrUp), .onBattery(onBattery),
    .irqOe(irqOe), .irqData(irqData), .rdAf(rdAf)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setAlarm(input logic [4:0] code, input logic [6:0] dayVal);
    for (int k = 0; k < 5; k++)
      writeReg(3'(k), {code[k], (k == 3) ? dayVal : alarmSet[k]});
  endtask

  task automatic setCur(input int diffIdx, input logic [6:0] dayVal);
    curSec   = alarmSet[0] ^ ((diffIdx == 0) ? 7'h01 : 7'h00);
    curMin   = alarmSet[1] ^ ((diffIdx == 1) ? 7'h01 : 7'h00);
    curHour  = alarmSet[2] ^ ((diffIdx == 2) ? 7'h01 : 7'h00);
    curDay   = dayVal      ^ ((diffIdx == 3) ? 7'h01 : 7'h00);
    curMonth = alarmSet[4] ^ ((diffIdx == 4) ? 7'h01 : 7'h00);
  endtask

  task automatic pulseTick();
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
  endtask

  task automatic readFlags(output logic val);
    @(negedge clk); rdFlags = 1'b1;
    @(negedge clk); rdFlags = 1'b0;
    val = rdAf;
  endtask

  // Fields required by a repeat code, bit 0 = seconds; illegal codes need none.
  function automatic logic [4:0] needFields(input logic [4:0] code);
    if (code == 5'b11111) return 5'b00000;
    for (int n = 1; n <= 5; n++)
      if (code == 5'((32'h1f << n) & 32'h1f)) return 5'((1 << n) - 1);
    return 5'b00000;
  endfunction

  function automatic bit isLegal(input logic [4:0] code);
    for (int n = 0; n <= 5; n++)
      if (code == 5'((32'h1f << n) & 32'h1f)) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic v;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 irqOe", irqOe, 1'b0);
    check("R10 irqData", irqData, 1'b1);
    check("R10 rdAf", rdAf, 1'b0);
    rstN = 1'b1;
    readFlags(v);
    check("R10 flag after reset", v, 1'b0);

    // R1 R2 R3 R5: sweep every repeat code against each single-field mismatch
    writeReg(3'd5, 8'h01);
    for (int code = 0; code < 32; code++) begin
      setAlarm(5'(code), alarmSet[3]);
      for (int d = -1; d < 5; d++) begin
        logic [4:0] need;
        logic expHit;
        need   = needFields(5'(code));
        expHit = (d < 0) || !need[d];
        setCur(d, alarmSet[3]);
        pulseTick();
        if (isLegal(5'(code))) check("R2 irq on match R5", irqOe, expHit);
        else                   check("R3 illegal code irq", irqOe, expHit);
        readFlags(v);
        if (isLegal(5'(code))) check("R2 flag R1", v, expHit);
        else                   check("R3 illegal code flag", v, expHit);
        check("R6 irq released by read", irqOe, 1'b0);
      end
    end

    // R4: matching fields without a tick never set the flag
    setAlarm(5'b00000, alarmSet[3]);
    setCur(-1, alarmSet[3]);
    repeat (5) @(negedge clk);
    readFlags(v);
    check("R4 no tick no flag", v, 1'b0);

    // R6: read and matching tick in the same cycle
    @(negedge clk); secTick = 1'b1; rdFlags = 1'b1;
    @(negedge clk); secTick = 1'b0; rdFlags = 1'b0;
    check("R6 read returns prior", rdAf, 1'b0);
    check("R6 irq from colliding match", irqOe, 1'b1);
    readFlags(v);
    check("R6 flag survived collision", v, 1'b1);
    readFlags(v);
    check("R6 flag cleared by read", v, 1'b0);

    // R5: flag enable clear on main power
    writeReg(3'd5, 8'h00);
    pulseTick();
    check("R5 no irq without enable", irqOe, 1'b0);
    readFlags(v);
    check("R5 flag still set", v, 1'b1);

    // R7: backup mode gating
    onBattery = 1'b1;
    writeReg(3'd5, 8'h01);
    pulseTick();
    check("R7 battery without abe", irqOe, 1'b0);
    readFlags(v);
    check("R7 flag set in backup", v, 1'b1);
    writeReg(3'd5, 8'h03);
    pulseTick();
    check("R7 battery with both enables", irqOe, 1'b1);
    readFlags(v);
    writeReg(3'd5, 8'h02);
    pulseTick();
    check("R7 battery abe only", irqOe, 1'b0);
    readFlags(v);
    onBattery = 1'b0;

    // R8: power-up clears the enables
    writeReg(3'd5, 8'h03);
    @(negedge clk); pwrUp = 1'b1;
    @(negedge clk); pwrUp = 1'b0;
    pulseTick();
    check("R8 no irq after power-up", irqOe, 1'b0);
    readFlags(v);
    check("R8 flag set after power-up", v, 1'b1);

    // R9: year code with zero day alarm is disabled
    writeReg(3'd5, 8'h01);
    setAlarm(5'b00000, 7'h00);
    setCur(-1, 7'h00);
    pulseTick();
    check("R9 disabled irq", irqOe, 1'b0);
    readFlags(v);
    check("R9 disabled flag", v, 1'b0);
    setAlarm(5'b11111, 7'h00);
    pulseTick();
    check("R9 zero day with repeat code still fires", irqOe, 1'b1);
    readFlags(v);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule